// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a watchdog for a microcontroller-style chip. It counts ticks from a slow free-running oscillator, and software must pulse a restart strobe before a chosen timeout runs out. If the strobe does not arrive in time, the watchdog raises an interrupt, asks for a system reset, or does the interrupt first and the reset on the following timeout. One 8-bit control/status register sets it up. The register is reached through a plain byte write port and a read port that is always valid.

The timeout is picked by a 4-bit code. Code n waits `BASE_TICKS * 2^n` ticks, and codes above 9 act like code 9. With the default base of 2000 ticks at 128 kHz, the timeouts run from about 16 ms to about 8 s. The four code bits are not next to each other in the register. The code and the reset-enable bit are guarded by a timed unlock sequence, so a stray write cannot switch the watchdog off.

The system-reset request goes to the chip's reset logic, but it does not reset this block. The reset enable and the running count therefore survive a watchdog reset, and the reset-cause flag shows that one happened.

Top module: `wdt_core`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0x00 and `irq`, `sys_rst_req` and `rst_cause` are low.
- R2: Register layout, from bit 7 down to bit 0: interrupt flag, interrupt enable, code bit 3, change enable, reset enable, code bits 2..0. Code n (0..9) times out after `BASE_TICKS << n` ticks of counting. Codes 10..15 behave as code 9.
- R3: The counter advances only in cycles where `tick` is high, and only while the interrupt enable or the reset enable is set.
- R4: A `kick` pulse clears the count. Kicks that keep arriving before the limit prevent every timeout.
- R5: With only the interrupt enable set, each timeout sets the flag (bit 7). `irq` follows the flag. The count restarts from zero and times out again periodically, and `sys_rst_req` is never raised.
- R6: A write with bit 7 = 1 clears the flag. A write with bit 7 = 0 leaves it unchanged.
- R7: With only the reset enable set, a timeout gives a `sys_rst_req` pulse that lasts exactly one clock cycle and sets `rst_cause`.
- R8: With both enables set, the first timeout sets the flag and clears the interrupt enable (bit 6). The next timeout without a kick in between raises `sys_rst_req`.
- R9: Any register write clears `rst_cause`. The reset enable stays set after a watchdog reset, and the counter keeps running, so reset pulses repeat.
- R10: An unlock write (a write with bits 4 and 3 both set, made while the window is closed) opens a window. The reset enable and the code change only on a write that lands in the 4 cycles after that unlock write. Any other write leaves them unchanged.
- R11: Bit 4 reads 1 while the window is open. It clears after the timed write, or after 4 cycles if no write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle enable from the slow oscillator |
| kick | input | 1 | Restart strobe; clears the count |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| irq | output | 1 | Interrupt request (level, equal to the flag) |
| sys_rst_req | output | 1 | One-cycle system-reset request |
| rst_cause | output | 1 | Set when this block requested a reset |

## Verification
The hardest state to reach from the ports is the second stage of combined mode. There, a timeout has already cleared the interrupt enable, so the next timeout must turn into a reset. Getting there takes an unlock write, a timed write setting both enables, and a wait through one full timeout without kicks. The stimulus then measures the second interval to the reset pulse, and repeats the setup with kicks after the first interrupt to show that the reset is prevented. The window edges are probed with a write in the last accepted cycle and with another one cycle too late. The bench is built with a base of 4 ticks so that every code, including the reserved ones, can be timed exactly.

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned BASE_TICKS = 2000,
  parameter int unsigned MAX_CODE   = 9,
  parameter int unsigned WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       sys_rst_req,
  output logic       rst_cause
);
  localparam int unsigned SPAN  = BASE_TICKS << MAX_CODE;
  localparam int unsigned CNT_W = $clog2(SPAN);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);

  logic             flag_q, ie_q, re_q, rst_q, cause_q;
  logic [3:0]       sel_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;

  logic             win_open, timed_wr, unlock_wr, running, expire;
  logic [3:0]       sel_eff;
  logic [CNT_W:0]   limit;

  assign win_open  = win_q != '0;
  assign timed_wr  = wr_en && win_open;
  assign unlock_wr = wr_en && !win_open && wr_data[4] && wr_data[3];
  assign sel_eff   = (sel_q > 4'(MAX_CODE)) ? 4'(MAX_CODE) : sel_q;
  assign limit     = (CNT_W+1)'(BASE_TICKS) << sel_eff;
  assign running   = ie_q | re_q;
  assign expire    = running && tick && !kick && ({1'b0, cnt_q} >= limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!running || kick) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      re_q    <= 1'b0;
      sel_q   <= '0;
      win_q   <= '0;
      rst_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      if (expire && ie_q)            flag_q <= 1'b1;
      else if (wr_en && wr_data[7])  flag_q <= 1'b0;

      if (expire && ie_q && re_q)    ie_q <= 1'b0;
      else if (wr_en)                ie_q <= wr_data[6];

      if (timed_wr) begin
        re_q  <= wr_data[3];
        sel_q <= {wr_data[5], wr_data[2:0]};
      end

      if (unlock_wr)      win_q <= WIN_W'(WIN_CYCLES);
      else if (timed_wr)  win_q <= '0;
      else if (win_open)  win_q <= win_q - 1'b1;

      rst_q <= expire && re_q && !ie_q;

      if (expire && re_q && !ie_q) cause_q <= 1'b1;
      else if (wr_en)              cause_q <= 1'b0;
    end
  end

  assign rd_data     = {flag_q, ie_q, sel_q[3], win_open, re_q, sel_q[2:0]};
  assign irq         = flag_q;
  assign sys_rst_req = rst_q;
  assign rst_cause   = cause_q;

  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  a_r7_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> rst_cause);
  a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt_q == '0);
  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !win_open) |=> ($stable(re_q) && $stable(sel_q)));
  a_r5_no_reset_int_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && !re_q) |=> !sys_rst_req);
  a_r8_ie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ie_q && re_q) |=> (!ie_q && flag_q && !sys_rst_req));
  a_r11_window_from_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(wr_en && wr_data[4] && wr_data[3]));
endmodule

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;
  localparam int unsigned BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, sys_rst_req, rst_cause;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  wdt_core #(.BASE_TICKS(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq(irq), .sys_rst_req(sys_rst_req), .rst_cause(rst_cause)
  );

  always #2.5 clk = ~clk;

  // code, expected ticks to timeout with BASE = 4 (R2)
  localparam int VEC [16][2] = '{
    '{0, 4}, '{1, 8}, '{2, 16}, '{3, 32}, '{4, 64}, '{5, 128},
    '{6, 256}, '{7, 512}, '{8, 1024}, '{9, 2048}, '{10, 2048},
    '{11, 2048}, '{12, 2048}, '{13, 2048}, '{14, 2048}, '{15, 2048}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse_kick();
    kick = 1'b1;
    @(posedge clk); #1;
    kick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b1; kick = 1'b0; wr_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wait_for(input bit want_rst, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!(want_rst ? sys_rst_req : irq) && n < 5000);
  endtask

  function automatic logic [7:0] code_bits(input int c);
    logic [3:0] s = 4'(c);
    return {2'b00, s[3], 2'b00, s[2:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    do_reset();
    // R1
    check("R1 rd_data", rd_data, 0);
    check("R1 irq/rst/cause", {irq, sys_rst_req, rst_cause}, 0);

    // R2: every code, interrupt-only mode
    for (int i = 0; i < 16; i++) begin
      do_reset();
      wr(8'h18);
      wr(8'h40 | code_bits(VEC[i][0]));
      wait_for(1'b0, n);
      check($sformatf("R2 code %0d", VEC[i][0]), n, VEC[i][1]);
    end

    // R11 / R10: window opens, times out after 4 cycles, late write ignored
    do_reset();
    wr(8'h18);
    check("R11 window bit set", rd_data[4], 1);
    idle(4);
    check("R11 window closed after 4", rd_data[4], 0);
    wr(8'h0D);
    check("R10 late write ignored", rd_data, 0);
    do_reset();
    wr(8'h18);
    idle(3);
    wr(8'h0D);
    check("R10 write in last window cycle", rd_data, 8'h0D);
    do_reset();
    wr(8'h0D);
    check("R10 unlocked-less write ignored", rd_data, 0);

    // R3: tick gating
    do_reset();
    wr(8'h18);
    wr(8'h40);
    tick = 1'b0;
    idle(50);
    check("R3 no count without tick", irq, 0);
    tick = 1'b1;
    wait_for(1'b0, n);
    check("R3 count resumes", n, 4);

    // R5 / R6: periodic interrupt, flag clear rules
    do_reset();
    wr(8'h18);
    wr(8'h40);
    wait_for(1'b0, n);
    check("R5 first expiry", n, 4);
    wr(8'h40);
    check("R6 write 0 keeps flag", rd_data[7], 1);
    // after E4 (cnt 0) and this write edge (cnt 1); clear at next edge (cnt 2)
    wr(8'hC0);
    check("R6 write 1 clears flag", irq, 0);
    wait_for(1'b0, n);
    check("R5 periodic re-expiry", n, 2);
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (sys_rst_req) seen = 1'b1;
    end
    check("R5 never resets", seen, 0);

    // R4: kicks prevent timeout (code 1, limit 8)
    do_reset();
    wr(8'h18);
    wr(8'h41);
    seen = 1'b0;
    for (int k = 0; k < 30; k++) begin
      idle(5);
      if (irq) seen = 1'b1;
      pulse_kick();
    end
    check("R4 kicks prevent expiry", seen, 0);
    wait_for(1'b0, n);
    check("R4 expiry after kicks stop", n, 8);

    // R7 / R9: reset-only mode
    do_reset();
    wr(8'h18);
    wr(8'h08);
    wait_for(1'b1, n);
    check("R7 reset after limit", n, 4);
    check("R7 cause set", rst_cause, 1);
    idle(1);
    check("R7 one-cycle pulse", sys_rst_req, 0);
    check("R7 no interrupt", irq, 0);
    wr(8'h00);
    check("R9 write clears cause", rst_cause, 0);
    check("R9 reset enable persists", rd_data[3], 1);
    wait_for(1'b1, n);
    check("R9 counter keeps running", n, 2);

    // R8: combined mode
    do_reset();
    wr(8'h18);
    wr(8'h48);
    wait_for(1'b0, n);
    check("R8 interrupt first", n, 4);
    check("R8 no reset at first expiry", sys_rst_req, 0);
    check("R8 ie cleared", rd_data[6], 0);
    wait_for(1'b1, n);
    check("R8 reset on next expiry", n, 4);
    do_reset();
    wr(8'h18);
    wr(8'h48);
    wait_for(1'b0, n);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      idle(2);
      if (sys_rst_req) seen = 1'b1;
      pulse_kick();
    end
    check("R8 kicks after interrupt avert reset", seen, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule